// File: doc/BRIEF.md
# FIFO Threshold Interrupt Controller

This block is the interrupt section of a serial flash controller. It watches the fill levels of the transmit and receive FIFOs, which live outside the block, and watches two event pulses, one for receive overflow and one for transmit underflow. From these it builds a seven-bit status word. The two event conditions are sticky, and software clears them by writing ones. The four level conditions follow the FIFOs live, and two of them compare a fill level against a watermark that software programs.

Software cannot write the enable mask directly. It raises mask bits by writing ones to a set register and drops mask bits by writing ones to a separate clear register. A read-only view of the mask shows the result. The single interrupt line is a registered OR of the status bits that are enabled. The register port is a simple write strobe with a combinational read of the addressed register, and reads have no side effects.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: After reset the mask is all zero, both watermarks read 1, both sticky bits are clear and `irq` is low.
- R2: The register offsets are 0x04 for status (read, write-one-to-clear), 0x08 for mask set (write only), 0x0C for mask clear (write only), 0x10 for mask view (read only), 0x28 for the transmit watermark and 0x2C for the receive watermark. Reads of 0x08, 0x0C and any other offset return 0.
- R3: Status, set, clear and mask registers all share one bit layout: 0 receive overflow, 2 transmit below watermark, 3 transmit full, 4 receive at or above watermark, 5 receive full, 6 transmit underflow. Bit 1 and bits 7 and up read 0 and cannot be enabled.
- R4: Status bit 2 is 1 exactly while `txLevel` is less than the transmit watermark, so a watermark of 1 flags an empty FIFO and a watermark of 0 never flags.
- R5: Status bit 4 is 1 while `rxLevel` is at or above the receive watermark. Bit 3 is 1 while `txLevel` equals DEPTH, and bit 5 is 1 while `rxLevel` equals DEPTH.
- R6: A pulse on `rxOverflowPulse` sets bit 0 and a pulse on `txUnderflowPulse` sets bit 6. Each stays set until a 1 is written to its position at offset 0x04. A pulse wins over a clear in the same cycle. Writing 1s to the level bits has no effect.
- R7: A write to 0x08 sets the mask bits written as 1, and a write to 0x0C clears the mask bits written as 1. Bits written as 0 keep their value. A write to 0x10 changes nothing.
- R8: `irq` equals the OR of (status AND mask) as it stood in the previous cycle, so it lags a status or mask change by one clock.
- R9: A watermark write keeps the low LEVEL_W bits of `wrData`, and a read returns that value zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte offset for read and write |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Combinational read data of the addressed register |
| txLevel | input | LEVEL_W | Transmit FIFO fill level |
| rxLevel | input | LEVEL_W | Receive FIFO fill level |
| rxOverflowPulse | input | 1 | One-cycle receive overflow event |
| txUnderflowPulse | input | 1 | One-cycle transmit underflow event |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench checks the case where an event pulse and a status clear land in the same cycle. A design that gives priority to the clear would lose that event, and bit 6 or bit 0 would read 0. It also sweeps each fill level across its watermark, including the exact boundary and a watermark of 0. An off-by-one compare would show a flag one level early or late. Mask writes with some bits 0, and writes to the read-only mask offset, expose a mask that is written as a plain register instead of being set and cleared. The one-cycle lag of `irq` is compared on every clock against a reference model, so a combinational or doubly registered interrupt fails at once.

// File: rtl/fic_pkg.sv
package fic_pkg;
  localparam int OFS_STATUS = 'h04;
  localparam int OFS_SET    = 'h08;
  localparam int OFS_CLR    = 'h0C;
  localparam int OFS_MASK   = 'h10;
  localparam int OFS_TXWM   = 'h28;
  localparam int OFS_RXWM   = 'h2C;

  localparam int NUM_BITS     = 7;
  localparam int BIT_RX_OVF   = 0;
  localparam int BIT_TX_LOW   = 2;
  localparam int BIT_TX_FULL  = 3;
  localparam int BIT_RX_AVAIL = 4;
  localparam int BIT_RX_FULL  = 5;
  localparam int BIT_TX_UNDER = 6;

  localparam logic [NUM_BITS-1:0] IMPL_BITS   = 7'b111_1101;
  localparam logic [NUM_BITS-1:0] STICKY_BITS = 7'b100_0001;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_STATUS, SEL_MASK, SEL_TXWM, SEL_RXWM
  } rdSel_e;

  typedef struct packed {
    logic   clrStatus;
    logic   setMask;
    logic   clrMask;
    logic   loadTxWm;
    logic   loadRxWm;
    rdSel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/fic_ctrl.sv
module fic_ctrl
  import fic_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           strobe
);
  always_comb begin
    strobe = '0;
    case (addr)
      ADDR_W'(OFS_STATUS): begin
        strobe.rdSel     = SEL_STATUS;
        strobe.clrStatus = wrEn;
      end
      ADDR_W'(OFS_SET):  strobe.setMask = wrEn;
      ADDR_W'(OFS_CLR):  strobe.clrMask = wrEn;
      ADDR_W'(OFS_MASK): strobe.rdSel   = SEL_MASK;
      ADDR_W'(OFS_TXWM): begin
        strobe.rdSel    = SEL_TXWM;
        strobe.loadTxWm = wrEn;
      end
      ADDR_W'(OFS_RXWM): begin
        strobe.rdSel    = SEL_RXWM;
        strobe.loadRxWm = wrEn;
      end
      default: strobe.rdSel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/fic_datapath.sv
module fic_datapath
  import fic_pkg::*;
#(
  parameter int DEPTH   = 63,
  parameter int LEVEL_W = 6,
  parameter int DATA_W  = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobe,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [LEVEL_W-1:0]  txLevel,
  input  logic [LEVEL_W-1:0]  rxLevel,
  input  logic                rxOverflowPulse,
  input  logic                txUnderflowPulse,
  output logic [DATA_W-1:0]   rdData,
  output logic [NUM_BITS-1:0] statusWord,
  output logic [NUM_BITS-1:0] maskWord,
  output logic                irq
);
  localparam logic [LEVEL_W-1:0] FULL_LEVEL = LEVEL_W'(DEPTH);

  logic [NUM_BITS-1:0] stickyBits;
  logic [NUM_BITS-1:0] liveBits;
  logic [NUM_BITS-1:0] maskQ;
  logic [LEVEL_W-1:0]  txWmQ;
  logic [LEVEL_W-1:0]  rxWmQ;
  logic [NUM_BITS-1:0] wrBits;
  logic                unusedBits;

  assign wrBits     = wrData[NUM_BITS-1:0] & IMPL_BITS;
  assign unusedBits = ^wrData;

  for (genvar i = 0; i < NUM_BITS; i++) begin : g_bit
    if (STICKY_BITS[i]) begin : g_sticky
      logic evt;
      logic q;
      if (i == BIT_RX_OVF) begin : g_ovf
        assign evt = rxOverflowPulse;
      end else begin : g_und
        assign evt = txUnderflowPulse;
      end
      always_ff @(posedge clk) begin
        if (!rstN)                              q <= 1'b0;
        else if (evt)                           q <= 1'b1;
        else if (strobe.clrStatus && wrData[i]) q <= 1'b0;
      end
      assign stickyBits[i] = q;
    end else begin : g_level
      assign stickyBits[i] = 1'b0;
    end
  end

  always_comb begin
    liveBits               = '0;
    liveBits[BIT_TX_LOW]   = txLevel < txWmQ;
    liveBits[BIT_TX_FULL]  = txLevel == FULL_LEVEL;
    liveBits[BIT_RX_AVAIL] = rxLevel >= rxWmQ;
    liveBits[BIT_RX_FULL]  = rxLevel == FULL_LEVEL;
  end

  assign statusWord = stickyBits | liveBits;
  assign maskWord   = maskQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ <= '0;
      txWmQ <= LEVEL_W'(1);
      rxWmQ <= LEVEL_W'(1);
      irq   <= 1'b0;
    end else begin
      if (strobe.setMask)  maskQ <= maskQ | wrBits;
      if (strobe.clrMask)  maskQ <= maskQ & ~wrBits;
      if (strobe.loadTxWm) txWmQ <= wrData[LEVEL_W-1:0];
      if (strobe.loadRxWm) rxWmQ <= wrData[LEVEL_W-1:0];
      irq <= |(statusWord & maskQ);
    end
  end

  always_comb begin
    case (strobe.rdSel)
      SEL_STATUS: rdData = DATA_W'(statusWord);
      SEL_MASK:   rdData = DATA_W'(maskQ);
      SEL_TXWM:   rdData = DATA_W'(txWmQ);
      SEL_RXWM:   rdData = DATA_W'(rxWmQ);
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
  import fic_pkg::*;
#(
  parameter int DEPTH   = 63,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  localparam int LEVEL_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic [LEVEL_W-1:0] txLevel,
  input  logic [LEVEL_W-1:0] rxLevel,
  input  logic               rxOverflowPulse,
  input  logic               txUnderflowPulse,
  output logic               irq
);
  strobe_t             strobe;
  logic [NUM_BITS-1:0] statusWord;
  logic [NUM_BITS-1:0] maskWord;

  fic_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn   (wrEn),
    .addr   (addr),
    .strobe (strobe)
  );

  fic_datapath #(.DEPTH(DEPTH), .LEVEL_W(LEVEL_W), .DATA_W(DATA_W)) u_dp (
    .clk              (clk),
    .rstN             (rstN),
    .strobe           (strobe),
    .wrData           (wrData),
    .txLevel          (txLevel),
    .rxLevel          (rxLevel),
    .rxOverflowPulse  (rxOverflowPulse),
    .txUnderflowPulse (txUnderflowPulse),
    .rdData           (rdData),
    .statusWord       (statusWord),
    .maskWord         (maskWord),
    .irq              (irq)
  );
endmodule

// File: rtl/fic_checker.sv
module fic_checker
  import fic_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic [ADDR_W-1:0]   addr,
  input logic [DATA_W-1:0]   wrData,
  input logic                rxOverflowPulse,
  input logic [NUM_BITS-1:0] statusWord,
  input logic [NUM_BITS-1:0] maskWord,
  input logic                irq
);
  logic                unusedBits;
  logic [NUM_BITS-1:0] wrImpl;
  logic                wrSet, wrClr, wrStat;

  assign unusedBits = ^wrData;
  assign wrImpl = wrData[NUM_BITS-1:0] & IMPL_BITS;
  assign wrSet  = wrEn && addr == ADDR_W'(OFS_SET);
  assign wrClr  = wrEn && addr == ADDR_W'(OFS_CLR);
  assign wrStat = wrEn && addr == ADDR_W'(OFS_STATUS);

  p_irq_lag_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> irq == $past(|(statusWord & maskWord)));

  p_ovf_sets_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxOverflowPulse |=> statusWord[BIT_RX_OVF]);

  p_sticky_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[BIT_RX_OVF] && !(wrStat && wrData[BIT_RX_OVF])) |=> statusWord[BIT_RX_OVF]);

  p_mask_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrSet |=> (maskWord & $past(wrImpl)) == $past(wrImpl));

  p_mask_clr_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrClr |=> (maskWord & $past(wrImpl)) == '0);

  p_mask_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(wrSet || wrClr) |=> $stable(maskWord));
endmodule

bind fifo_irq_ctrl fic_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk             (clk),
  .rstN            (rstN),
  .wrEn            (wrEn),
  .addr            (addr),
  .wrData          (wrData),
  .rxOverflowPulse (rxOverflowPulse),
  .statusWord      (statusWord),
  .maskWord        (maskWord),
  .irq             (irq)
);

// File: tb/fifo_irq_ctrl_tb.sv
module fifo_irq_ctrl_tb;
  localparam int DEPTH = 63;
  localparam int LW    = 6;
  localparam int AW    = 8;
  localparam int DW    = 32;

  logic          clk = 1'b0;
  logic          rstN;
  logic          wrEn;
  logic [AW-1:0] addr;
  logic [DW-1:0] wrData;
  logic [DW-1:0] rdData;
  logic [LW-1:0] txLevel, rxLevel;
  logic          rxOverflowPulse, txUnderflowPulse;
  logic          irq;

  always #5 clk = ~clk;

  fifo_irq_ctrl #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .txLevel(txLevel), .rxLevel(rxLevel),
    .rxOverflowPulse(rxOverflowPulse), .txUnderflowPulse(txUnderflowPulse),
    .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int mMask, mTxWm, mRxWm, mSt;
  bit mOvf, mUnd, mIrq;

  function automatic int modelStatus();
    int s = 0;
    if (mOvf) s |= 'h01;
    if (int'(txLevel) < mTxWm) s |= 'h04;
    if (int'(txLevel) == DEPTH) s |= 'h08;
    if (int'(rxLevel) >= mRxWm) s |= 'h10;
    if (int'(rxLevel) == DEPTH) s |= 'h20;
    if (mUnd) s |= 'h40;
    return s;
  endfunction

  function automatic int modelRead(int a);
    case (a)
      'h04: return modelStatus();
      'h10: return mMask;
      'h28: return mTxWm;
      'h2C: return mRxWm;
      default: return 0;
    endcase
  endfunction

  // reference model, advanced on each rising edge from the inputs held there
  always @(posedge clk) begin
    if (!rstN) begin
      mMask = 0; mTxWm = 1; mRxWm = 1; mOvf = 0; mUnd = 0; mIrq = 0;
    end else begin
      mSt  = modelStatus();
      mIrq = (mSt & mMask) != 0;
      if (rxOverflowPulse) mOvf = 1;
      else if (wrEn && addr == 'h04 && wrData[0]) mOvf = 0;
      if (txUnderflowPulse) mUnd = 1;
      else if (wrEn && addr == 'h04 && wrData[6]) mUnd = 0;
      if (wrEn && addr == 'h08) mMask = mMask | (int'(wrData) & 'h7D);
      if (wrEn && addr == 'h0C) mMask = mMask & ~(int'(wrData) & 'h7D);
      if (wrEn && addr == 'h28) mTxWm = int'(wrData) & ((1 << LW) - 1);
      if (wrEn && addr == 'h2C) mRxWm = int'(wrData) & ((1 << LW) - 1);
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // R8: interrupt line compared against the model every clock
  always @(posedge clk) begin
    #2;
    if (!done) check(irq === mIrq, "R8", int'(irq), int'(mIrq));
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    wrEn = 1'b1; addr = AW'(a); wrData = DW'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(int a, int exp, string tag);
    @(negedge clk);
    wrEn = 1'b0; addr = AW'(a);
    #1;
    check(int'(rdData) == exp, tag, int'(rdData), exp);
    check(int'(rdData) == modelRead(a), tag, int'(rdData), modelRead(a));
  endtask

  task automatic levels(int t, int r);
    @(negedge clk);
    txLevel = LW'(t); rxLevel = LW'(r);
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog: actual timeout expected completion");
      done = 1;
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; addr = '0; wrData = '0;
    txLevel = '0; rxLevel = '0; rxOverflowPulse = 1'b0; txUnderflowPulse = 1'b0;
    settle(3);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    rd('h10, 0, "R1");
    rd('h28, 1, "R1");
    rd('h2C, 1, "R1");
    rd('h04, 'h04, "R1");
    check(irq === 1'b0, "R1", int'(irq), 0);
    // R2 write-only and unmapped offsets read zero
    rd('h08, 0, "R2");
    rd('h0C, 0, "R2");
    rd('h00, 0, "R2");

    // R3 only implemented bits can be enabled; R7 set and clear
    wr('h08, 'hFFFF_FFFF);
    rd('h10, 'h7D, "R3");
    wr('h0C, 'h7D);
    rd('h10, 0, "R7");
    wr('h08, 'h04);
    settle(2);
    check(irq === 1'b1, "R8", int'(irq), 1);
    wr('h10, 'h7D);
    rd('h10, 'h04, "R7");
    wr('h08, 'h10);
    wr('h0C, 'h00);
    rd('h10, 'h14, "R7");

    // R4 / R5 level flags
    levels(1, 0);
    rd('h04, 'h00, "R4");
    levels(DEPTH, 0);
    rd('h04, 'h08, "R5");
    levels(DEPTH, 1);
    rd('h04, 'h18, "R5");
    levels(DEPTH, DEPTH);
    rd('h04, 'h38, "R5");

    // R9 watermark width, R4 boundary
    wr('h28, 'hFFFF_FF05);
    rd('h28, 5, "R9");
    levels(4, 0);
    rd('h04, 'h04, "R4");
    levels(5, 0);
    rd('h04, 'h00, "R4");
    wr('h2C, 3);
    levels(5, 2);
    rd('h04, 'h00, "R5");
    levels(5, 3);
    rd('h04, 'h10, "R5");

    // R6 sticky events
    wr('h08, 'h41);
    @(negedge clk) rxOverflowPulse = 1'b1;
    @(negedge clk) rxOverflowPulse = 1'b0;
    settle(3);
    rd('h04, 'h11, "R6");
    wr('h04, 'h3C);
    rd('h04, 'h11, "R6");
    wr('h04, 'h01);
    rd('h04, 'h10, "R6");
    @(negedge clk) begin
      txUnderflowPulse = 1'b1; wrEn = 1'b1; addr = 'h04; wrData = 'h40;
    end
    @(negedge clk) begin
      txUnderflowPulse = 1'b0; wrEn = 1'b0;
    end
    rd('h04, 'h50, "R6");
    wr('h04, 'h40);
    rd('h04, 'h10, "R6");

    // R4 / R5 watermark of zero
    wr('h28, 0);
    wr('h2C, 0);
    levels(0, 0);
    rd('h04, 'h10, "R4");

    // mixed traffic, compared against the model
    for (int i = 0; i < 3000; i++) begin
      int pick;
      @(negedge clk);
      txLevel = LW'($urandom_range(0, DEPTH));
      rxLevel = LW'($urandom_range(0, DEPTH));
      rxOverflowPulse  = ($urandom_range(0, 15) == 0);
      txUnderflowPulse = ($urandom_range(0, 15) == 0);
      pick = $urandom_range(0, 7);
      case (pick)
        0: addr = 'h04; 1: addr = 'h08; 2: addr = 'h0C; 3: addr = 'h10;
        4: addr = 'h28; 5: addr = 'h2C; 6: addr = 'h00; default: addr = 'h14;
      endcase
      wrEn = ($urandom_range(0, 3) == 0);
      wrData = DW'($urandom);
      #1;
      check(int'(rdData) == modelRead(int'(addr)), "R2", int'(rdData), modelRead(int'(addr)));
    end
    @(negedge clk) begin
      wrEn = 1'b0; rxOverflowPulse = 1'b0; txUnderflowPulse = 1'b0;
    end

    // R1 reset in mid-run
    wr('h08, 'h7D);
    @(negedge clk) rstN = 1'b0;
    settle(2);
    @(negedge clk) rstN = 1'b1;
    rd('h10, 0, "R1");
    rd('h28, 1, "R1");
    settle(3);

    done = 1;
    summary();
    $finish;
  end
endmodule